// File: doc/BRIEF.md
# Set/Clear Register GPIO Bank

A bank of 32 general-purpose pins controlled over a small strobe-based register bus. Software never has to read, modify and write back an output word: one register raises the pins named in a mask, another lowers them, and both of these also enable the output driver of every named pin. A third register turns drivers back off, so the named pins become inputs. Pins that are not named in a mask are never touched.

The input side samples every pin through a two-flop synchronizer. It stays dark until software writes once to an arming register, whatever the written value. Before that, the pin-state register reads as zero. Read data is registered: it appears in the cycle after the read strobe and is zero in every other cycle.

Register map (word address): 0 output-set, 1 output-clear, 2 driver-off, 3 pin-state (read only), 4 input-arm. Addresses 5 to 7 are not used.

Top module: `gpio_bank`

## Requirements
- R1: After reset, `pin_o` and `pin_oe_o` are all zeros, `rdata_o` is zero, and the input path is disarmed.
- R2: A write of mask M to address 0 sets `pin_o` bit n to 1 for each set bit n of M, at the next clock edge. All other `pin_o` bits keep their values.
- R3: A write of mask M to address 1 clears `pin_o` bit n to 0 for each set bit n of M, at the next clock edge. All other `pin_o` bits keep their values.
- R4: A write to address 0 or address 1 sets `pin_oe_o` bit n for each set bit n of the mask. All other `pin_oe_o` bits keep their values.
- R5: A write of mask M to address 2 clears `pin_oe_o` bit n for each set bit n of M. `pin_o` and all other `pin_oe_o` bits keep their values.
- R6: While the input path is disarmed, a read of address 3 returns zero, whatever the pin levels are.
- R7: Any write to address 4 arms the input path for good, including a write of zero. After that, a read of address 3 returns the synchronized level of `pin_i`, with bit n giving pin n.
- R8: A change on `pin_i` reaches a pin-state read through two synchronizer flops. When `pin_i` changes just after an edge, reads whose strobes are sampled at the next two edges still return the old value, and the read at the third edge returns the new value.
- R9: Reads of addresses 0, 1, 2, 4 and 5 to 7 return zero. Writes to addresses 5 to 7 change neither `pin_o`, `pin_oe_o` nor the arming state.
- R10: `rdata_o` carries the value of the read in the cycle after a `rd_en_i` strobe and is zero after a cycle with no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data / pin mask |
| rdata_o | output | 32 | Registered read data |
| pin_i | input | 32 | Pin input levels |
| pin_o | output | 32 | Pin output levels |
| pin_oe_o | output | 32 | Per-pin output driver enable |

## Verification
The hardest case to reach from the ports is the timing of the synchronizer relative to arming and reading. To cover it, the bench changes `pin_i` just after an edge and then issues back-to-back reads, so the exact cycle in which the new level first becomes visible is pinned down. Before any arming write, it also drives nonzero pins, fills the undefined addresses with all-ones writes and performs reads, to show that the input path stays dark. Every pin is then swept one at a time through set, clear and driver-off, and an expected latch and enable word is kept arithmetically and compared after every write.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_OUT_SET   = 3'd0,
    REG_OUT_CLR   = 3'd1,
    REG_DRV_OFF   = 3'd2,
    REG_PIN_STATE = 3'd3,
    REG_IN_ARM    = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] pin_state_i,
  output logic                set_we_o,
  output logic                clr_we_o,
  output logic                off_we_o,
  output logic                arm_we_o,
  output logic [NUM_PINS-1:0] rdata_o
);
  logic [NUM_PINS-1:0] rdata_q;

  assign set_we_o = wr_en_i && (addr_i == REG_OUT_SET);
  assign clr_we_o = wr_en_i && (addr_i == REG_OUT_CLR);
  assign off_we_o = wr_en_i && (addr_i == REG_DRV_OFF);
  assign arm_we_o = wr_en_i && (addr_i == REG_IN_ARM);

  // only the pin-state address is readable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  rdata_q <= '0;
    else if (rd_en_i && addr_i == REG_PIN_STATE)  rdata_q <= pin_state_i;
    else                                          rdata_q <= '0;
  end

  assign rdata_o = rdata_q;

  assert_idle_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> rdata_o == '0);

  assert_wo_read_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i != REG_PIN_STATE) |=> rdata_o == '0);
endmodule

// File: rtl/gpio_bank_outregs.sv
module gpio_bank_outregs #(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_we_i,
  input  logic                clr_we_i,
  input  logic                off_we_i,
  input  logic [NUM_PINS-1:0] mask_i,
  output logic [NUM_PINS-1:0] level_o,
  output logic [NUM_PINS-1:0] oe_o
);
  logic [NUM_PINS-1:0] level_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
      oe_q    <= '0;
    end else begin
      if (set_we_i)      level_q <= level_q | mask_i;
      else if (clr_we_i) level_q <= level_q & ~mask_i;
      // a level write also claims the pins as outputs
      if (set_we_i || clr_we_i) oe_q <= oe_q | mask_i;
      else if (off_we_i)        oe_q <= oe_q & ~mask_i;
    end
  end

  assign level_o = level_q;
  assign oe_o    = oe_q;

  assert_set_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we_i |=> ((level_o & $past(mask_i)) == $past(mask_i)) &&
                 ((level_o & ~$past(mask_i)) == ($past(level_o) & ~$past(mask_i))));

  assert_clr_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((level_o & $past(mask_i)) == '0) &&
                 ((level_o & ~$past(mask_i)) == ($past(level_o) & ~$past(mask_i))));

  assert_drive_on_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_we_i || clr_we_i) |=> (oe_o & $past(mask_i)) == $past(mask_i));

  assert_drive_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_we_i |=> ((oe_o & $past(mask_i)) == '0) && $stable(level_o));
endmodule

// File: rtl/gpio_bank_insync.sv
module gpio_bank_insync #(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                arm_we_i,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic                armed_o,
  output logic [NUM_PINS-1:0] state_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [NUM_PINS-1:0] stage_q [SYNC_STAGES];
  logic                armed_q;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  // sticky: data value of the arming write is irrelevant
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       armed_q <= 1'b0;
    else if (arm_we_i) armed_q <= 1'b1;
  end

  assign armed_o = armed_q;
  assign state_o = armed_q ? stage_q[LAST] : '0;

  assert_arm_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> armed_q);

  assert_arm_on_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_we_i |=> armed_q);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o
);
  logic                set_we, clr_we, off_we, arm_we, armed;
  logic [NUM_PINS-1:0] pin_state;

  gpio_bank_decode #(.NUM_PINS(NUM_PINS)) u_decode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .rd_en_i     (rd_en_i),
    .addr_i      (addr_i),
    .pin_state_i (pin_state),
    .set_we_o    (set_we),
    .clr_we_o    (clr_we),
    .off_we_o    (off_we),
    .arm_we_o    (arm_we),
    .rdata_o     (rdata_o)
  );

  gpio_bank_outregs #(.NUM_PINS(NUM_PINS)) u_outregs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_we_i (set_we),
    .clr_we_i (clr_we),
    .off_we_i (off_we),
    .mask_i   (wdata_i),
    .level_o  (pin_o),
    .oe_o     (pin_oe_o)
  );

  gpio_bank_insync #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_insync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_we_i (arm_we),
    .pin_i    (pin_i),
    .armed_o  (armed),
    .state_o  (pin_state)
  );

  assert_dark_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !armed) |=> rdata_o == '0);

  assert_undef_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i > REG_IN_ARM) |=> $stable(pin_o) && $stable(pin_oe_o) &&
                                         (armed == $past(armed)));
endmodule

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, pin_in = '0;
  logic [31:0] rdata, pin_out, pin_oe;
  logic [31:0] exp_out = '0, exp_oe = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      3'd0: begin exp_out |= d;  exp_oe |= d; end
      3'd1: begin exp_out &= ~d; exp_oe |= d; end
      3'd2: exp_oe &= ~d;
      default: ;
    endcase
  endtask

  // strobe at one edge, sample at the following negedge
  task automatic bus_read(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic check_outs(string req);
    check({req, " level"}, pin_out, exp_out);
    check({req, " enable"}, pin_oe, exp_oe);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 level", pin_out, 32'h0);
    check("R1 enable", pin_oe, 32'h0);
    check("R1 rdata", rdata, 32'h0);

    // R6 disarmed reads stay dark; R9 undefined writes ignored
    pin_in = 32'hA5A5_F00F;
    repeat (3) @(negedge clk);
    bus_read(3'd3, r);
    check("R6 dark", r, 32'h0);
    for (int a = 5; a < 8; a++) begin
      bus_write(3'(a), 32'hFFFF_FFFF);
      check_outs("R9 undef write");
      bus_read(3'd3, r);
      check("R9 undef write arm", r, 32'h0);
    end

    // R2 R3 R4 R5 single-pin sweep
    for (int i = 0; i < 32; i++) begin
      bus_write(3'd0, 32'd1 << i);
      check_outs("R2 set");
      bus_write(3'd2, 32'd1 << i);
      check_outs("R5 off");
      bus_write(3'd1, 32'd1 << i);
      check_outs("R3 clr");
      bus_write(3'd0, 32'd1 << i);
      check_outs("R4 reenable");
    end

    // multi-bit patterns
    for (int k = 0; k < 24; k++) begin
      logic [31:0] p;
      p = (32'h9E37_79B9 * (k + 1)) ^ (32'h0101_0101 << (k % 8));
      case (k % 3)
        0: begin bus_write(3'd0, p); check_outs("R2 pattern"); end
        1: begin bus_write(3'd1, p); check_outs("R3 pattern"); end
        default: begin bus_write(3'd2, p); check_outs("R5 pattern"); end
      endcase
    end

    // R9 write-only addresses read as zero
    for (int a = 0; a < 8; a++) begin
      if (a == 3) continue;
      bus_read(3'(a), r);
      check("R9 read zero", r, 32'h0);
    end

    // R10 no strobe, no data
    @(negedge clk);
    check("R10 idle", rdata, 32'h0);

    // R7 arm with zero data
    bus_write(3'd4, 32'h0);
    check_outs("R7 arm side effect");
    bus_read(3'd3, r);
    check("R7 armed read", r, 32'hA5A5_F00F);
    @(negedge clk);
    check("R10 after read", rdata, 32'h0);

    // R8 latency: old, old, new
    @(negedge clk);
    pin_in = 32'h1234_5678;
    rd_en = 1'b1; addr = 3'd3;
    @(negedge clk); check("R8 edge1", rdata, 32'hA5A5_F00F);
    @(negedge clk); check("R8 edge2", rdata, 32'hA5A5_F00F);
    @(negedge clk); check("R8 edge3", rdata, 32'h1234_5678);
    rd_en = 1'b0;

    // R7 sweep of input levels
    for (int i = 0; i < 32; i++) begin
      pin_in = ~(32'd1 << i);
      repeat (2) @(negedge clk);
      bus_read(3'd3, r);
      check("R7 walk", r, ~(32'd1 << i));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule